// File: doc/BRIEF.md
# Package Low-Power State Controller

This block follows the package-level power state of a multi-core processor, two cores by default. It moves through four visible states: Normal, Stop-Grant, Stop-Grant Snoop and Sleep. Inputs are an active-low stop-clock request, an active-low sleep request and a snoop/interrupt detect strobe with its matching "serviced or latched" indication. The block also reads each core's present C-state and a per-core ready flag. When stop-clock is seen, the block pulses an acknowledge and records every core's C-state. It then grants Stop-Grant to each core as that core becomes ready. A core already in a deep C-state counts as granted at once.

Each core takes its recorded C-state back when the package returns to Normal. A bus-clock deadline bounds the entry phase. If a core misses the deadline, a sticky flag is raised and the grant is forced. A synchronous re-initialise input clears the block's history but keeps a package that is out of Normal in Stop-Grant. A sleep request that starts outside Stop-Grant raises a one-cycle error pulse and is ignored until it is released.

Top module: `pkg_pwr_ctrl`

## Requirements
- R1: After reset, `pkg_state` is 0, `clk_en` is 1, and `sg_ack`, `core_sg_ent`, `sg_timeout`, `slp_err` and `core_prior` are all 0. State codes are 0 Normal, 1 Stop-Grant, 2 Snoop, 3 Sleep.
- R2: A low `stop_req_n` sampled in Normal makes `sg_ack` high for exactly the next cycle. The package reports 0 while cores are entering. It reports 1 on the edge where every core is granted, which is the edge after the last `core_rdy` bit is sampled high.
- R3: On the stop-clock edge each core's `core_cstate` field is stored in `core_prior` (3 bits per core, core 0 in the low bits). The C-state codes are 0 C0, 1 C1 halt, 2 C1 monitor-wait, 3 C2, 4 C3 and 5 C4. A core whose code is 3, 4 or 5 has `core_sg_ent` set on that same edge.
- R4: If not every core is granted by the 20th edge after the acknowledge edge, `sg_timeout` is set on that edge. On the same edge all grants are forced and the package reports 1. `sg_timeout` stays set until reset or `sys_init`.
- R5: In Stop-Grant, a high `snoop_det` moves the package to 2. The package stays in 2, whatever stop-clock does, until `snoop_done` is high, and then it returns to 1. Snoop takes priority over sleep and exit.
- R6: In Stop-Grant, a low `sleep_req_n` moves the package to 3 and drives `clk_en` low. A high `sleep_req_n` returns it to 1. Stop-clock has no effect in Sleep.
- R7: The package returns to Normal only from Stop-Grant, when `stop_req_n` is high. On that edge `core_sg_ent` clears and `core_prior` keeps the stored states.
- R8: A falling `sleep_req_n` sampled while the package is not in Stop-Grant gives a one-cycle `slp_err` pulse. The request is then ignored until `sleep_req_n` goes high again.
- R9: A high `sys_init` puts the package into 1 if it was not in Normal, and leaves it in 0 if it was. It also clears `sg_timeout` and `core_prior`. In the Stop-Grant case every `core_sg_ent` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_init | input | 1 | Synchronous re-initialise request |
| stop_req_n | input | 1 | Stop-clock request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| snoop_det | input | 1 | Snoop or interrupt detected |
| snoop_done | input | 1 | Snoop serviced or interrupt latched |
| core_cstate | input | NCORES*3 | Present C-state of each core |
| core_rdy | input | NCORES | Core is ready to stop |
| pkg_state | output | 2 | Package state code |
| core_sg_ent | output | NCORES | Per-core Stop-Grant granted |
| core_prior | output | NCORES*3 | Recorded C-state each core resumes |
| clk_en | output | 1 | Internal clock enable, low in Sleep |
| sg_ack | output | 1 | One-cycle stop-grant acknowledge |
| sg_timeout | output | 1 | Sticky entry deadline overrun |
| slp_err | output | 1 | Illegal sleep request pulse |

## Verification
All results come from registers. A state change, the acknowledge, the grant bits, the recorded C-states and the error pulse therefore all appear one edge after the input that causes them is sampled. The one exception is the timeout, which is due on the 20th edge after the acknowledge edge. The bench changes inputs on the falling clock edge and checks outputs on the next falling edge, so every check falls exactly one rising edge after its stimulus. The deadline test checks the package state just before the limit edge and again on it.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  localparam int CSW = 3;

  typedef enum logic [2:0] {
    PS_NORMAL = 3'd0,
    PS_ENTER  = 3'd1,
    PS_SG     = 3'd2,
    PS_SNOOP  = 3'd3,
    PS_SLEEP  = 3'd4
  } pwr_st_e;

  localparam logic [CSW-1:0] CS_C0  = 3'd0;
  localparam logic [CSW-1:0] CS_C2  = 3'd3;
  localparam logic [CSW-1:0] CS_C4  = 3'd5;

  localparam logic [1:0] PKG_NORMAL = 2'd0;
  localparam logic [1:0] PKG_SG     = 2'd1;
  localparam logic [1:0] PKG_SNOOP  = 2'd2;
  localparam logic [1:0] PKG_SLEEP  = 2'd3;

  function automatic logic is_deep(input logic [CSW-1:0] cs);
    return (cs >= CS_C2) && (cs <= CS_C4);
  endfunction

endpackage

// File: rtl/pwr_core_slot.sv
module pwr_core_slot import pwr_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init,
  input  logic           init_hold,
  input  logic           load,
  input  logic           step,
  input  logic           force_in,
  input  logic           drop,
  input  logic           rdy,
  input  logic [CSW-1:0] cs_in,
  output logic           entered,
  output logic [CSW-1:0] prior
);

  logic           ent_d;
  logic           ent_en;
  logic [CSW-1:0] pri_d;
  logic           pri_en;

  always_comb begin
    ent_d  = entered;
    ent_en = 1'b0;
    pri_d  = prior;
    pri_en = 1'b0;
    if (init) begin
      ent_en = 1'b1;
      ent_d  = init_hold;
      pri_en = 1'b1;
      pri_d  = CS_C0;
    end else if (load) begin
      ent_en = 1'b1;
      ent_d  = is_deep(cs_in);
      pri_en = 1'b1;
      pri_d  = cs_in;
    end else if (drop) begin
      ent_en = 1'b1;
      ent_d  = 1'b0;
    end else if (force_in) begin
      ent_en = 1'b1;
      ent_d  = 1'b1;
    end else if (step && rdy) begin
      ent_en = 1'b1;
      ent_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entered <= 1'b0;
      prior   <= CS_C0;
    end else begin
      if (ent_en) entered <= ent_d;
      if (pri_en) prior   <= pri_d;
    end
  end

endmodule

// File: rtl/pwr_deadline.sv
module pwr_deadline #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | run;
    if (clr)              cnt_d = '0;
    else if (cnt == LAST) cnt_d = cnt;
    else                  cnt_d = cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

endmodule

// File: rtl/pwr_sleep_guard.sv
module pwr_sleep_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req_n,
  input  logic in_sg,
  output logic sleep_ok,
  output logic err
);

  logic slp_q;
  logic bad;
  logic fall;
  logic bad_d;
  logic err_d;

  always_comb begin
    fall     = slp_q & ~sleep_req_n;
    err_d    = fall & ~in_sg;
    bad_d    = sleep_req_n ? 1'b0 : (bad | err_d);
    sleep_ok = ~sleep_req_n & ~bad_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_q <= 1'b1;
      bad   <= 1'b0;
      err   <= 1'b0;
    end else begin
      slp_q <= sleep_req_n;
      bad   <= bad_d;
      err   <= err_d;
    end
  end

endmodule

// File: rtl/pkg_pwr_ctrl.sv
module pkg_pwr_ctrl import pwr_pkg::*; #(
  parameter int NCORES      = 2,
  parameter int SG_DEADLINE = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sys_init,
  input  logic                    stop_req_n,
  input  logic                    sleep_req_n,
  input  logic                    snoop_det,
  input  logic                    snoop_done,
  input  logic [NCORES*CSW-1:0]   core_cstate,
  input  logic [NCORES-1:0]       core_rdy,
  output logic [1:0]              pkg_state,
  output logic [NCORES-1:0]       core_sg_ent,
  output logic [NCORES*CSW-1:0]   core_prior,
  output logic                    clk_en,
  output logic                    sg_ack,
  output logic                    sg_timeout,
  output logic                    slp_err
);

  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rsync;
  logic                   rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i = rsync[SYNC_STAGES-1];

  pwr_st_e st;
  pwr_st_e st_d;

  logic all_in;
  logic expired;
  logic sleep_ok;
  logic load;
  logic step;
  logic force_all;
  logic go_normal;
  logic init_hold;
  logic to_d;
  logic to_en;

  pwr_deadline #(.LIMIT(SG_DEADLINE)) u_deadline (
    .clk     (clk),
    .rst_n   (rst_i),
    .clr     (load),
    .run     (step),
    .expired (expired)
  );

  pwr_sleep_guard u_sleep (
    .clk         (clk),
    .rst_n       (rst_i),
    .sleep_req_n (sleep_req_n),
    .in_sg       (st == PS_SG),
    .sleep_ok    (sleep_ok),
    .err         (slp_err)
  );

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    pwr_core_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_i),
      .init      (sys_init),
      .init_hold (init_hold),
      .load      (load),
      .step      (step),
      .force_in  (force_all),
      .drop      (go_normal),
      .rdy       (core_rdy[i]),
      .cs_in     (core_cstate[i*CSW +: CSW]),
      .entered   (core_sg_ent[i]),
      .prior     (core_prior[i*CSW +: CSW])
    );
  end

  always_comb begin
    all_in    = &(core_sg_ent | core_rdy);
    init_hold = (st != PS_NORMAL);
    load      = (st == PS_NORMAL) && !stop_req_n && !sys_init;
    step      = (st == PS_ENTER) && !sys_init;
    force_all = step && expired && !all_in;
    go_normal = (st == PS_SG) && !sys_init && !snoop_det && !sleep_ok && stop_req_n;
  end

  // next state
  always_comb begin
    st_d = st;
    if (sys_init) begin
      st_d = (st == PS_NORMAL) ? PS_NORMAL : PS_SG;
    end else begin
      case (st)
        PS_NORMAL: if (!stop_req_n)        st_d = PS_ENTER;
        PS_ENTER:  if (all_in || expired)  st_d = PS_SG;
        PS_SG: begin
          if (snoop_det)     st_d = PS_SNOOP;
          else if (sleep_ok) st_d = PS_SLEEP;
          else if (go_normal) st_d = PS_NORMAL;
        end
        PS_SNOOP:  if (snoop_done)  st_d = PS_SG;
        PS_SLEEP:  if (sleep_req_n) st_d = PS_SG;
        default:   st_d = PS_NORMAL;
      endcase
    end
  end

  always_comb begin
    to_en = sys_init | force_all;
    to_d  = !sys_init;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st         <= PS_NORMAL;
      sg_ack     <= 1'b0;
      sg_timeout <= 1'b0;
    end else begin
      st     <= st_d;
      sg_ack <= load;
      if (to_en) sg_timeout <= to_d;
    end
  end

  always_comb begin
    case (st)
      PS_SG:    pkg_state = PKG_SG;
      PS_SNOOP: pkg_state = PKG_SNOOP;
      PS_SLEEP: pkg_state = PKG_SLEEP;
      default:  pkg_state = PKG_NORMAL;
    endcase
    clk_en = (st != PS_SLEEP);
  end

endmodule

// File: rtl/pkg_pwr_chk.sv
module pkg_pwr_chk #(
  parameter int NCORES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_init,
  input logic              sleep_req_n,
  input logic [1:0]        pkg_state,
  input logic [NCORES-1:0] core_sg_ent,
  input logic              sg_ack,
  input logic              sg_timeout,
  input logic              slp_err
);

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sg_ack |=> !sg_ack); // R2

  AST_GRANTED_IN_SG: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state == 2'd1) |-> (&core_sg_ent)); // R2

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sg_timeout) && !$past(sys_init)) |-> sg_timeout); // R4

  AST_SNOOP_FROM_SG: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state == 2'd2 && $past(pkg_state) != 2'd2) |-> ($past(pkg_state) == 2'd1)); // R5

  AST_SLEEP_FROM_SG: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state == 2'd3 && $past(pkg_state) != 2'd3) |-> ($past(pkg_state) == 2'd1)); // R6

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state == 2'd3 && !sleep_req_n && !sys_init) |=> (pkg_state == 2'd3)); // R6

  AST_NORMAL_FROM_SG: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state == 2'd0 && $past(pkg_state) != 2'd0) |-> ($past(pkg_state) == 2'd1)); // R7

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slp_err |=> !slp_err); // R8

endmodule

bind pkg_pwr_ctrl pkg_pwr_chk #(.NCORES(NCORES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sys_init    (sys_init),
  .sleep_req_n (sleep_req_n),
  .pkg_state   (pkg_state),
  .core_sg_ent (core_sg_ent),
  .sg_ack      (sg_ack),
  .sg_timeout  (sg_timeout),
  .slp_err     (slp_err)
);

// File: tb/sim_pkg_pwr_ctrl.sv
module sim_pkg_pwr_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NC         = 2;
  localparam int LIMIT      = 20;
  localparam int NVEC       = 11;

  // [7] stop_n [6] sleep_n [5] snoop_det [4] snoop_done
  // [3] expected ack [2] expected clk_en [1:0] expected state
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1100_0100,  // idle in Normal
    8'b0100_1100,  // stop seen: ack, still reported Normal
    8'b0100_0101,  // all ready: Stop-Grant
    8'b0110_0110,  // snoop: Snoop
    8'b1100_0110,  // stop released inside Snoop: no effect
    8'b0100_0110,  // waiting for service
    8'b0101_0101,  // serviced: back to Stop-Grant
    8'b0000_0011,  // sleep: Sleep, clocks off
    8'b1000_0011,  // stop released in Sleep: no effect
    8'b1100_0101,  // sleep released: Stop-Grant
    8'b1100_0100   // stop released: Normal
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            sys_init;
  logic            stop_req_n;
  logic            sleep_req_n;
  logic            snoop_det;
  logic            snoop_done;
  logic [NC*3-1:0] core_cstate;
  logic [NC-1:0]   core_rdy;
  logic [1:0]      pkg_state;
  logic [NC-1:0]   core_sg_ent;
  logic [NC*3-1:0] core_prior;
  logic            clk_en;
  logic            sg_ack;
  logic            sg_timeout;
  logic            slp_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkg_pwr_ctrl #(.NCORES(NC), .SG_DEADLINE(LIMIT)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_init    (sys_init),
    .stop_req_n  (stop_req_n),
    .sleep_req_n (sleep_req_n),
    .snoop_det   (snoop_det),
    .snoop_done  (snoop_done),
    .core_cstate (core_cstate),
    .core_rdy    (core_rdy),
    .pkg_state   (pkg_state),
    .core_sg_ent (core_sg_ent),
    .core_prior  (core_prior),
    .clk_en      (clk_en),
    .sg_ack      (sg_ack),
    .sg_timeout  (sg_timeout),
    .slp_err     (slp_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    sys_init    = 1'b0;
    stop_req_n  = 1'b1;
    sleep_req_n = 1'b1;
    snoop_det   = 1'b0;
    snoop_done  = 1'b0;
    core_cstate = '0;
    core_rdy    = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1", "state",   pkg_state,   0);
    chk("R1", "clk_en",  clk_en,      1);
    chk("R1", "ack",     sg_ack,      0);
    chk("R1", "ent",     core_sg_ent, 0);
    chk("R1", "timeout", sg_timeout,  0);
    chk("R1", "err",     slp_err,     0);
    chk("R1", "prior",   core_prior,  0);

    // table walk: R2 entry, R5 snoop, R6 sleep, R7 exit
    for (int i = 0; i < NVEC; i++) begin
      stop_req_n  = VEC[i][7];
      sleep_req_n = VEC[i][6];
      snoop_det   = VEC[i][5];
      snoop_done  = VEC[i][4];
      step();
      chk("R2 R5 R6 R7", $sformatf("vec%0d state", i),  pkg_state, {30'd0, VEC[i][1:0]});
      chk("R2 R5 R6 R7", $sformatf("vec%0d clk_en", i), clk_en,    {31'd0, VEC[i][2]});
      chk("R2 R5 R6 R7", $sformatf("vec%0d ack", i),    sg_ack,    {31'd0, VEC[i][3]});
    end
    snoop_det  = 1'b0;
    snoop_done = 1'b0;

    // R3 deep core granted at once, prior captured
    core_cstate = {3'd0, 3'd4};
    core_rdy    = 2'b00;
    stop_req_n  = 1'b0;
    step();
    chk("R3", "ent",   core_sg_ent, 2'b01);
    chk("R3", "prior", core_prior,  {3'd0, 3'd4});
    chk("R2", "state while entering", pkg_state, 0);
    core_rdy = 2'b10;
    step();
    chk("R2", "state after last ready", pkg_state, 1);
    chk("R2", "ent all", core_sg_ent, 2'b11);
    // R7 exit keeps prior
    core_cstate = '0;
    core_rdy    = 2'b11;
    stop_req_n  = 1'b1;
    step();
    chk("R7", "state", pkg_state, 0);
    chk("R7", "ent cleared", core_sg_ent, 0);
    chk("R7", "prior kept", core_prior, {3'd0, 3'd4});

    // R4 deadline
    core_cstate = {3'd1, 3'd0};
    core_rdy    = 2'b00;
    stop_req_n  = 1'b0;
    step();
    repeat (LIMIT - 1) step();
    chk("R4", "state before limit", pkg_state, 0);
    chk("R4", "timeout before limit", sg_timeout, 0);
    step();
    chk("R4", "state at limit", pkg_state, 1);
    chk("R4", "timeout at limit", sg_timeout, 1);
    chk("R4", "forced ent", core_sg_ent, 2'b11);
    chk("R4", "prior", core_prior, {3'd1, 3'd0});
    core_rdy   = 2'b11;
    stop_req_n = 1'b1;
    step();
    chk("R4", "timeout sticky", sg_timeout, 1);
    chk("R7", "state", pkg_state, 0);

    // R9 re-initialise
    stop_req_n = 1'b0;
    step();
    step();
    chk("R9", "pre state", pkg_state, 1);
    sys_init = 1'b1;
    step();
    sys_init = 1'b0;
    chk("R9", "state kept", pkg_state, 1);
    chk("R9", "timeout cleared", sg_timeout, 0);
    chk("R9", "prior cleared", core_prior, 0);
    chk("R9", "ent set", core_sg_ent, 2'b11);
    stop_req_n = 1'b1;
    step();
    chk("R9", "exit", pkg_state, 0);
    sys_init = 1'b1;
    step();
    sys_init = 1'b0;
    chk("R9", "normal stays", pkg_state, 0);

    // R8 illegal sleep
    sleep_req_n = 1'b0;
    step();
    chk("R8", "err pulse", slp_err, 1);
    chk("R8", "state", pkg_state, 0);
    step();
    chk("R8", "err ends", slp_err, 0);
    stop_req_n = 1'b0;
    step();
    step();
    chk("R8", "in SG", pkg_state, 1);
    step();
    chk("R8", "sleep ignored", pkg_state, 1);
    chk("R8", "clocks on", clk_en, 1);
    sleep_req_n = 1'b1;
    step();
    sleep_req_n = 1'b0;
    step();
    chk("R6", "legal sleep", pkg_state, 3);
    chk("R6", "clocks off", clk_en, 0);
    chk("R8", "no err", slp_err, 0);
    sleep_req_n = 1'b1;
    step();
    stop_req_n = 1'b1;
    step();
    chk("R7", "final normal", pkg_state, 0);

    finish_run();
  end

endmodule